// File: doc/BRIEF.md
# I2C Master Interrupt Status Unit

This block holds the raw interrupt status of an I2C master controller that moves data through transmit and receive FIFOs in bursts. Single-cycle event strobes from the bus engine and DMA logic set most of its status bits. FIFO fill levels, trigger thresholds and the remaining burst byte count set the rest. Every status bit is sticky. It stays set until software writes a one to the matching position of a write-one-to-clear register.

A read/write enable mask selects which raw bits can raise the single interrupt line. That line is the OR of the masked bits, taken through one register stage. Software uses a small word-addressed register bus. It can read the raw status and the masked status, read and write the mask, and write the clear register. The bus takes single-cycle write strobes and returns read data combinationally.

Top module: `i2c_irq_status`

## Requirements
- R1: Raw status bit positions are: 0 transfer done, 1 clock timeout, 2 DMA receive done, 3 DMA transmit done, 4 NACK, 5 START seen, 6 STOP seen, 7 arbitration lost, 8 TX request, 9 RX request, 10 TX FIFO empty, 11 RX FIFO full. Bits 31..12 of every read are zero.
- R2: Reset is synchronous and active high. It clears all raw bits, the mask and the interrupt output.
- R3: Writing 1 at a position of the clear register (word address 3) clears that raw bit at the next clock edge. Writing 0 leaves the bit unchanged. Writes to the raw status address (word address 0) have no effect.
- R4: When a set condition and a clear write hit the same bit in the same cycle, the bit ends up set.
- R5: Each of the eight event strobes (bits 0..7) sets its bit at the clock edge where it is high. The bit then holds until it is cleared.
- R6: The TX FIFO empty bit sets only on a clock edge where the TX level is zero and the level seen at the previous edge was non-zero. If it is cleared while the FIFO stays empty, it stays clear.
- R7: The RX request bit sets while the RX level is non-zero and either the level is at or above the RX trigger or the remaining burst count is zero.
- R8: The TX request bit sets while the TX level is at or below the TX trigger and the remaining burst count is non-zero.
- R9: The RX FIFO full bit sets when the RX level first reaches the FIFO depth. It stays set after the level falls, until it is cleared.
- R10: The 12-bit mask at word address 1 can be read and written. Word address 2 reads the raw status ANDed with the mask.
- R11: The interrupt output equals the OR of the masked status bits as they stood one clock edge earlier.
- R12: The clear register always reads as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Combinational register read data |
| xfer_done_evt | input | 1 | Transfer done strobe |
| clk_tmo_evt | input | 1 | Clock timeout strobe |
| dma_rx_done_evt | input | 1 | DMA receive done strobe |
| dma_tx_done_evt | input | 1 | DMA transmit done strobe |
| nack_evt | input | 1 | NACK received strobe |
| start_evt | input | 1 | START condition strobe |
| stop_evt | input | 1 | STOP condition strobe |
| arb_lost_evt | input | 1 | Arbitration lost strobe |
| tx_level | input | 4 | TX FIFO fill level |
| tx_trig | input | 4 | TX FIFO trigger level |
| rx_level | input | 4 | RX FIFO fill level |
| rx_trig | input | 4 | RX FIFO trigger level |
| burst_left | input | 8 | Bytes remaining in the current burst |
| irq | output | 1 | Registered interrupt request |

## Verification
A strobe or level condition present before a rising edge shows up in the raw and masked reads right after that edge. A clear write takes effect at the edge that samples it. The interrupt line lags the masked status by one more edge. The bench drives inputs on falling edges and samples one falling edge after the edge that captures them. Its interrupt checks expect the line still low at that first sample and high one cycle later. The TX empty edge needs two edges, one to record a non-empty level and one to see it drop to zero, so those checks come after the second edge.

// File: rtl/i2c_irq_pkg.sv
package i2c_irq_pkg;
  localparam int NUM_IRQ = 12;
  localparam int NUM_EVT = 8;

  localparam int BIT_TX_REQ   = 8;
  localparam int BIT_RX_REQ   = 9;
  localparam int BIT_TX_EMPTY = 10;
  localparam int BIT_RX_FULL  = 11;

  localparam logic [1:0] ADDR_RAW    = 2'd0;
  localparam logic [1:0] ADDR_MASK   = 2'd1;
  localparam logic [1:0] ADDR_MASKED = 2'd2;
  localparam logic [1:0] ADDR_CLEAR  = 2'd3;

  typedef logic [NUM_IRQ-1:0] irq_vec_t;
endpackage

// File: rtl/i2c_irq_set_gen.sv
module i2c_irq_set_gen
  import i2c_irq_pkg::*;
#(
  parameter int LVL_W      = 4,
  parameter int BURST_W    = 8,
  parameter int FIFO_DEPTH = 8
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [NUM_EVT-1:0]     evt,
  input  logic [LVL_W-1:0]       tx_level,
  input  logic [LVL_W-1:0]       tx_trig,
  input  logic [LVL_W-1:0]       rx_level,
  input  logic [LVL_W-1:0]       rx_trig,
  input  logic [BURST_W-1:0]     burst_left,
  output irq_vec_t               set_vec
);
  localparam logic [LVL_W-1:0] FULL_LVL = LVL_W'(FIFO_DEPTH);

  logic tx_empty, rx_full, prev_tx_empty, prev_rx_full;
  logic tx_req, rx_req, burst_done;

  assign tx_empty   = (tx_level == '0);
  assign rx_full    = (rx_level == FULL_LVL);
  assign burst_done = (burst_left == '0);

  // Start with the TX FIFO treated as empty, so reset produces no edge.
  always_ff @(posedge clk) begin
    if (rst) begin
      prev_tx_empty <= 1'b1;
      prev_rx_full  <= 1'b0;
    end else begin
      prev_tx_empty <= tx_empty;
      prev_rx_full  <= rx_full;
    end
  end

  assign tx_req = (tx_level <= tx_trig) && !burst_done;
  assign rx_req = (rx_level != '0) && ((rx_level >= rx_trig) || burst_done);

  always_comb begin
    set_vec                = '0;
    set_vec[NUM_EVT-1:0]   = evt;
    set_vec[BIT_TX_REQ]    = tx_req;
    set_vec[BIT_RX_REQ]    = rx_req;
    set_vec[BIT_TX_EMPTY]  = tx_empty && !prev_tx_empty;
    set_vec[BIT_RX_FULL]   = rx_full && !prev_rx_full;
  end
endmodule

// File: rtl/i2c_irq_bit_reg.sv
module i2c_irq_bit_reg
  import i2c_irq_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  irq_vec_t set_vec,
  input  irq_vec_t clr_vec,
  output irq_vec_t raw_q
);
  for (genvar i = 0; i < NUM_IRQ; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst)             raw_q[i] <= 1'b0;
      else if (set_vec[i]) raw_q[i] <= 1'b1;
      else if (clr_vec[i]) raw_q[i] <= 1'b0;
    end
  end
endmodule

// File: rtl/i2c_irq_regbus.sv
module i2c_irq_regbus
  import i2c_irq_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic [1:0]        reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  input  irq_vec_t          raw_q,
  output irq_vec_t          mask_q,
  output irq_vec_t          clr_vec,
  output logic [DATA_W-1:0] reg_rdata
);
  always_ff @(posedge clk) begin
    if (rst)                                   mask_q <= '0;
    else if (reg_wr && reg_addr == ADDR_MASK)  mask_q <= reg_wdata[NUM_IRQ-1:0];
  end

  assign clr_vec = (reg_wr && reg_addr == ADDR_CLEAR) ? reg_wdata[NUM_IRQ-1:0] : '0;

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      ADDR_RAW:    reg_rdata[NUM_IRQ-1:0] = raw_q;
      ADDR_MASK:   reg_rdata[NUM_IRQ-1:0] = mask_q;
      ADDR_MASKED: reg_rdata[NUM_IRQ-1:0] = raw_q & mask_q;
      default:     reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/i2c_irq_status.sv
module i2c_irq_status
  import i2c_irq_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int LVL_W      = 4,
  parameter int BURST_W    = 8,
  parameter int FIFO_DEPTH = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               reg_wr,
  input  logic [1:0]         reg_addr,
  input  logic [DATA_W-1:0]  reg_wdata,
  output logic [DATA_W-1:0]  reg_rdata,
  input  logic               xfer_done_evt,
  input  logic               clk_tmo_evt,
  input  logic               dma_rx_done_evt,
  input  logic               dma_tx_done_evt,
  input  logic               nack_evt,
  input  logic               start_evt,
  input  logic               stop_evt,
  input  logic               arb_lost_evt,
  input  logic [LVL_W-1:0]   tx_level,
  input  logic [LVL_W-1:0]   tx_trig,
  input  logic [LVL_W-1:0]   rx_level,
  input  logic [LVL_W-1:0]   rx_trig,
  input  logic [BURST_W-1:0] burst_left,
  output logic               irq
);
  logic [NUM_EVT-1:0] evt;
  irq_vec_t set_vec, clr_vec, raw_q, mask_q;
  logic irq_q;

  assign evt = {arb_lost_evt, stop_evt, start_evt, nack_evt,
                dma_tx_done_evt, dma_rx_done_evt, clk_tmo_evt, xfer_done_evt};

  i2c_irq_set_gen #(.LVL_W(LVL_W), .BURST_W(BURST_W), .FIFO_DEPTH(FIFO_DEPTH)) u_set (
    .clk(clk), .rst(rst), .evt(evt),
    .tx_level(tx_level), .tx_trig(tx_trig),
    .rx_level(rx_level), .rx_trig(rx_trig),
    .burst_left(burst_left), .set_vec(set_vec)
  );

  i2c_irq_bit_reg u_bits (
    .clk(clk), .rst(rst), .set_vec(set_vec), .clr_vec(clr_vec), .raw_q(raw_q)
  );

  i2c_irq_regbus #(.DATA_W(DATA_W)) u_bus (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .raw_q(raw_q), .mask_q(mask_q),
    .clr_vec(clr_vec), .reg_rdata(reg_rdata)
  );

  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= |(raw_q & mask_q);
  end

  assign irq = irq_q;
endmodule

// File: rtl/i2c_irq_chk.sv
module i2c_irq_chk
  import i2c_irq_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input irq_vec_t          raw_q,
  input irq_vec_t          mask_q,
  input irq_vec_t          set_vec,
  input irq_vec_t          clr_vec,
  input logic              irq,
  input logic [DATA_W-1:0] reg_rdata
);
  // R4
  set_applied_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((raw_q & $past(set_vec)) == $past(set_vec)));

  // R3
  clear_applied_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((raw_q & $past(clr_vec & ~set_vec)) == '0));

  // R5
  bit_hold_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (((raw_q ^ $past(raw_q)) & ~$past(set_vec | clr_vec)) == '0));

  // R11
  irq_lag_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (irq == |($past(raw_q & mask_q))));

  // R1
  upper_zero_chk: assert property (@(posedge clk) disable iff (rst)
    reg_rdata[DATA_W-1:NUM_IRQ] == '0);
endmodule

bind i2c_irq_status i2c_irq_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .raw_q(raw_q), .mask_q(mask_q),
  .set_vec(set_vec), .clr_vec(clr_vec), .irq(irq), .reg_rdata(reg_rdata)
);

// File: tb/tb_i2c_irq_status.sv
module tb_i2c_irq_status;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic reg_wr = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [7:0] evt = '0;
  logic [3:0] tx_level = '0, tx_trig = '0, rx_level = '0, rx_trig = '0;
  logic [7:0] burst_left = '0;
  logic irq;
  int checks = 0;
  int fails = 0;
  logic [31:0] d;

  always #5 clk = ~clk;

  i2c_irq_status dut (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .xfer_done_evt(evt[0]), .clk_tmo_evt(evt[1]), .dma_rx_done_evt(evt[2]),
    .dma_tx_done_evt(evt[3]), .nack_evt(evt[4]), .start_evt(evt[5]),
    .stop_evt(evt[6]), .arb_lost_evt(evt[7]),
    .tx_level(tx_level), .tx_trig(tx_trig), .rx_level(rx_level),
    .rx_trig(rx_trig), .burst_left(burst_left), .irq(irq)
  );

  localparam int NV = 11;
  localparam logic [7:0] EVT_TAB [NV] = '{8'h01, 8'h02, 8'h04, 8'h08, 8'h10,
                                          8'h20, 8'h40, 8'h80, 8'hA5, 8'h5A, 8'hFF};

  task automatic tick; @(negedge clk); endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] v);
    reg_addr = a; #1; v = reg_rdata;
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] v);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = v;
    tick;
    reg_wr = 1'b0; reg_wdata = '0;
  endtask

  task automatic pulse(input logic [7:0] e);
    evt = e; tick; evt = '0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) tick;
    rst = 1'b0;
    tick;
    // R2 reset state
    rd(2'd0, d); chk("R2 raw", d, 0);
    rd(2'd1, d); chk("R2 mask", d, 0);
    chk("R2 irq", {31'd0, irq}, 0);
    rd(2'd3, d); chk("R12 clear reads zero", d, 0);

    // R5 R1: event table walk
    for (int i = 0; i < NV; i++) begin
      pulse(EVT_TAB[i]);
      rd(2'd0, d); chk("R5 event sets bit", d, {24'd0, EVT_TAB[i]});
      tick;
      rd(2'd0, d); chk("R5 bit holds", d, {24'd0, EVT_TAB[i]});
      wr(2'd3, 32'hFFF);
      rd(2'd0, d); chk("R3 clear all", d, 0);
    end

    // R3 zero-write clear and raw write ignored
    pulse(8'h30);
    wr(2'd3, 32'h0);
    rd(2'd0, d); chk("R3 clear zero no effect", d, 32'h30);
    wr(2'd0, 32'hFFFF_FFFF);
    rd(2'd0, d); chk("R3 raw write ignored", d, 32'h30);
    wr(2'd3, 32'h10);
    rd(2'd0, d); chk("R3 partial clear", d, 32'h20);
    wr(2'd3, 32'hFFFF_FFFF);
    rd(2'd3, d); chk("R12 clear reads zero after write", d, 0);
    rd(2'd0, d); chk("R1 upper bits zero", d, 0);

    // R4 set wins over clear
    reg_wr = 1'b1; reg_addr = 2'd3; reg_wdata = 32'h80; evt = 8'h80;
    tick;
    reg_wr = 1'b0; evt = '0;
    rd(2'd0, d); chk("R4 set wins", d & 32'h80, 32'h80);
    wr(2'd3, 32'hFFF);

    // R8 TX request
    tx_trig = 4'd3; tx_level = 4'd5; burst_left = 8'd5;
    tick;
    rd(2'd0, d); chk("R8 above trigger no req", d & 32'h100, 0);
    tx_level = 4'd2;
    tick;
    rd(2'd0, d); chk("R8 tx request", d & 32'h100, 32'h100);
    burst_left = 8'd0;
    wr(2'd3, 32'h100);
    tick;
    rd(2'd0, d); chk("R8 no req with burst done", d & 32'h100, 0);

    // R6 TX empty edge
    tx_level = 4'd0;
    tick;
    rd(2'd0, d); chk("R6 empty edge sets", d & 32'h400, 32'h400);
    wr(2'd3, 32'h400);
    repeat (3) tick;
    rd(2'd0, d); chk("R6 no reassert while empty", d & 32'h400, 0);
    tx_level = 4'd1; tick;
    rd(2'd0, d); chk("R6 no set while non-empty", d & 32'h400, 0);
    tx_level = 4'd0; tick;
    rd(2'd0, d); chk("R6 sets after refill and drain", d & 32'h400, 32'h400);
    wr(2'd3, 32'hFFF);

    // R7 RX request
    rx_trig = 4'd4; rx_level = 4'd2; burst_left = 8'd3;
    tick;
    rd(2'd0, d); chk("R7 below trigger no req", d & 32'h200, 0);
    rx_level = 4'd4; tick;
    rd(2'd0, d); chk("R7 trigger reached", d & 32'h200, 32'h200);
    rx_level = 4'd0;
    wr(2'd3, 32'h200);
    rd(2'd0, d); chk("R7 cleared when empty", d & 32'h200, 0);
    rx_level = 4'd1; burst_left = 8'd0; tick;
    rd(2'd0, d); chk("R7 data with burst done", d & 32'h200, 32'h200);

    // R9 RX full sticky
    rx_level = 4'd8; tick;
    rd(2'd0, d); chk("R9 full sets", d & 32'h800, 32'h800);
    rx_level = 4'd7; tick;
    rd(2'd0, d); chk("R9 full holds", d & 32'h800, 32'h800);
    rx_level = 4'd0;
    wr(2'd3, 32'hFFF);
    rd(2'd0, d); chk("R9 cleared", d, 0);

    // R10 R11 mask and irq
    wr(2'd1, 32'hFFFF_F001);
    rd(2'd1, d); chk("R10 mask readback", d, 32'h001);
    pulse(8'h02);
    tick; tick;
    chk("R10 masked-off no irq", {31'd0, irq}, 0);
    rd(2'd2, d); chk("R10 masked read excludes", d, 0);
    pulse(8'h01);
    rd(2'd2, d); chk("R10 masked read", d, 32'h001);
    chk("R11 irq not yet", {31'd0, irq}, 0);
    tick;
    chk("R11 irq one cycle later", {31'd0, irq}, 1);
    wr(2'd3, 32'h001);
    chk("R11 irq lags clear", {31'd0, irq}, 1);
    tick;
    chk("R11 irq drops", {31'd0, irq}, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule